// File: doc/BRIEF.md
# Extended Match Timer Bank

This block holds eight timer channels. Each channel owns a counter, a match value and a control word. The control word picks one of eight tick sources for the counter. It also decides whether the channel compares against its own counter or against the counter that leads its group. Its remaining bits set clear-on-match, repeat mode and snapshot-on-read. Each source arrives as a one-cycle tick-enable pulse from outside the block. A parameter mask says which sources exist; a counter that selects a missing source holds its value.

A match happens when the compared counter steps onto the channel's match value. If that channel's enable bit is set, the match raises its status bit. All eight status bits are merged into one interrupt line, which stays high until every bit has been cleared. Registers are written and read through a simple select/kind port. Reading the counter of channel 5 or 7 can also copy the count of the channel just below into a snapshot register.

Top module: `exttmr_bank`

## Requirements
- R1: Counter j steps by one on each cycle where tick[s] is high, s being its effective source. If bit s of SRC_PRESENT is clear, or no tick arrives, the counter holds.
- R2: With control bit 7 clear, channels 0–3 compare against counter 0, channels 4–5 against counter 4 and channels 6–7 against counter 6. With bit 7 set, a channel compares against its own counter.
- R3: A control write changes the effective source only if bit 7 is set or the channel owns a counter (channel 0, 4 or 6). On channels 4–7, control bit 8 forces source 0 whatever bits [2:0] hold.
- R4: Channels 0–3 keep control bits [7:0] and read zero above them. Channels 4–7 keep bits [9:0].
- R5: A match sets sts[i] only if irq_en[i] is high in that cycle.
- R6: With control bit 3 set, a match loads the compared counter with zero instead of the match value.
- R7: With control bit 6 set, a channel keeps matching. Without it, a channel matches once and is re-armed only by a write to its match or control register.
- R8: With control bit 9 set on channel 5 (or 7), reading that channel's counter copies counter 4 (or 6) into the snapshot register, which reads at kind 3.
- R9: irq is high while any sts bit is set. A sts_clr pulse clears the selected bits, and irq falls only once none remain.
- R10: A counter write (kind 0) loads wr_data on the next edge. Matching resumes from the loaded value.
- R11: After reset, all counters, match values, control words, status bits and the snapshot read zero, and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 8 | Per-source tick-enable pulses |
| wr_en | input | 1 | Register write strobe |
| wr_ch | input | 3 | Channel written |
| wr_reg | input | 2 | Register kind written: 0 counter, 1 match, 2 control |
| wr_data | input | CW | Write data |
| rd_en | input | 1 | Read strobe (snapshot side effect) |
| rd_ch | input | 3 | Channel read |
| rd_reg | input | 2 | Kind read: 0 counter, 1 match, 2 control, 3 snapshot |
| rd_data | output | CW | Read data (combinational) |
| irq_en | input | 8 | Per-channel status enables |
| sts_clr | input | 8 | Per-channel status clear pulses |
| sts | output | 8 | Per-channel status bits |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions check four things on every cycle. A status bit never rises while its enable is low. The interrupt never falls without a clear pulse. Counters hold when no tick arrives and no write happens. Counter loads and snapshots capture the right values one edge later. The bench scenarios cover what a single cycle cannot show: group sharing against the bit-7 override, the rule for when a source select takes effect, one-shot against repeating matches, clear-on-match wrap, control width masking, and absent sources.

// File: rtl/exttmr_bank.sv
module exttmr_bank #(
  parameter int CW = 32,
  parameter logic [7:0] SRC_PRESENT = 8'hDF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [7:0]    tick,
  input  logic          wr_en,
  input  logic [2:0]    wr_ch,
  input  logic [1:0]    wr_reg,
  input  logic [CW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [2:0]    rd_ch,
  input  logic [1:0]    rd_reg,
  output logic [CW-1:0] rd_data,
  input  logic [7:0]    irq_en,
  input  logic [7:0]    sts_clr,
  output logic [7:0]    sts,
  output logic          irq
);
  logic [7:0][CW-1:0] cnt, mat;
  logic [7:0][9:0]    ctrl;
  logic [7:0][2:0]    src;
  logic [7:0]         armed, adv, ev, clr;
  logic [CW-1:0]      snap;

  function automatic logic [2:0] cmp_idx(input int i, input logic own);
    if (own)        return 3'(i);
    else if (i < 4) return 3'd0;
    else if (i < 6) return 3'd4;
    else            return 3'd6;
  endfunction

  always_comb begin
    clr = '0;
    for (int j = 0; j < 8; j++)
      adv[j] = tick[src[j]] & SRC_PRESENT[src[j]];
    for (int i = 0; i < 8; i++) begin
      logic [2:0] c;
      c = cmp_idx(i, ctrl[i][7]);
      ev[i] = armed[i] & adv[c] & ((cnt[c] + CW'(1)) == mat[i]);
      if (ev[i] && ctrl[i][3]) clr[c] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0; mat <= '0; ctrl <= '0; src <= '0;
      armed <= '0; sts <= '0; snap <= '0;
    end else begin
      for (int i = 0; i < 8; i++) begin
        logic hit;
        hit = wr_en && (wr_ch == 3'(i));
        if (hit && wr_reg == 2'd0) cnt[i] <= wr_data;
        else if (clr[i])           cnt[i] <= '0;
        else if (adv[i])           cnt[i] <= cnt[i] + CW'(1);
        if (hit && wr_reg == 2'd1) mat[i] <= wr_data;
        if (hit && wr_reg == 2'd2) begin
          ctrl[i] <= (i < 4) ? {2'b00, wr_data[7:0]} : wr_data[9:0];
          if (wr_data[7] || i == 0 || i == 4 || i == 6)
            src[i] <= (i >= 4 && wr_data[8]) ? 3'd0 : wr_data[2:0];
        end
        if (hit && (wr_reg == 2'd1 || wr_reg == 2'd2)) armed[i] <= 1'b1;
        else if (ev[i] && !ctrl[i][6])                armed[i] <= 1'b0;
        sts[i] <= (sts[i] & ~sts_clr[i]) | (ev[i] & irq_en[i]);
      end
      if (rd_en && rd_reg == 2'd0 && rd_ch[0] && rd_ch[2] && ctrl[rd_ch][9])
        snap <= cnt[rd_ch - 3'd1];
    end
  end

  always_comb
    case (rd_reg)
      2'd0:    rd_data = cnt[rd_ch];
      2'd1:    rd_data = mat[rd_ch];
      2'd2:    rd_data = CW'(ctrl[rd_ch]);
      default: rd_data = snap;
    endcase

  assign irq = |sts;
endmodule

// File: rtl/exttmr_bank_chk.sv
module exttmr_bank_chk #(parameter int CW = 32) (
  input logic               clk,
  input logic               rst_n,
  input logic [7:0]         tick,
  input logic               wr_en,
  input logic [2:0]         wr_ch,
  input logic [1:0]         wr_reg,
  input logic [CW-1:0]      wr_data,
  input logic               rd_en,
  input logic [2:0]         rd_ch,
  input logic [1:0]         rd_reg,
  input logic [7:0]         irq_en,
  input logic [7:0]         sts_clr,
  input logic [7:0]         sts,
  input logic               irq,
  input logic [7:0][CW-1:0] cnt,
  input logic [7:0][9:0]    ctrl,
  input logic [CW-1:0]      snap
);
  p_rise_needs_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> ((sts & ~$past(sts) & ~$past(irq_en)) == 8'h00));

  p_fall_needs_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> ($past(sts_clr) != 8'h00));

  p_hold_without_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick == 8'h00 && !wr_en) |=> $stable(cnt));

  p_counter_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_reg == 2'd0) |=> (cnt[$past(wr_ch)] == $past(wr_data)));

  p_snapshot_copy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_reg == 2'd0 && rd_ch == 3'd5 && ctrl[5][9]) |=> (snap == $past(cnt[4])));
endmodule

bind exttmr_bank exttmr_bank_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_ch(wr_ch),
  .wr_reg(wr_reg), .wr_data(wr_data), .rd_en(rd_en), .rd_ch(rd_ch),
  .rd_reg(rd_reg), .irq_en(irq_en), .sts_clr(sts_clr), .sts(sts),
  .irq(irq), .cnt(cnt), .ctrl(ctrl), .snap(snap)
);

// File: tb/exttmr_bank_test.sv
module exttmr_bank_test;
  localparam int CW = 32;
  logic clk = 0, rst_n = 0;
  logic [7:0] tick = 0, irq_en = 0, sts_clr = 0, sts;
  logic wr_en = 0, rd_en = 0, irq;
  logic [2:0] wr_ch = 0, rd_ch = 0;
  logic [1:0] wr_reg = 0, rd_reg = 0;
  logic [CW-1:0] wr_data = 0, rd_data;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  exttmr_bank #(.CW(CW), .SRC_PRESENT(8'hDF)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_ch(wr_ch),
    .wr_reg(wr_reg), .wr_data(wr_data), .rd_en(rd_en), .rd_ch(rd_ch),
    .rd_reg(rd_reg), .rd_data(rd_data), .irq_en(irq_en), .sts_clr(sts_clr),
    .sts(sts), .irq(irq));

  task automatic check(input string req, input logic [CW-1:0] act, input logic [CW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input int ch, input int kind, input logic [CW-1:0] d);
    wr_en = 1; wr_ch = 3'(ch); wr_reg = 2'(kind); wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input int ch, input int kind, output logic [CW-1:0] v);
    rd_en = 1; rd_ch = 3'(ch); rd_reg = 2'(kind);
    #1 v = rd_data;
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic pulse(input logic [7:0] m, input int n);
    for (int k = 0; k < n; k++) begin
      tick = m;
      @(negedge clk);
      tick = 0;
    end
  endtask

  task automatic clear(input logic [7:0] m);
    sts_clr = m;
    @(negedge clk);
    sts_clr = 0;
  endtask

  task automatic t_reset;
    logic [CW-1:0] v;
    for (int ch = 0; ch < 8; ch++)
      for (int k = 0; k < 4; k++) begin
        rd(ch, k, v);
        check("R11 reset register", v, 0);
      end
    check("R11 reset irq", CW'(irq), 0);
    check("R11 reset sts", CW'(sts), 0);
  endtask

  task automatic t_count;
    logic [CW-1:0] v;
    wr(0, 2, 0); wr(0, 0, 0);
    pulse(8'h01, 5);
    rd(0, 0, v); check("R1 counter 0 steps on source 0", v, 5);
    wr(2, 2, 32'h85); wr(2, 0, 10);
    pulse(8'h20, 3); pulse(8'h01, 2);
    rd(2, 0, v); check("R1 absent source holds counter 2", v, 10);
    wr(2, 0, 77);
    rd(2, 0, v); check("R10 counter write loads", v, 77);
  endtask

  task automatic t_select;
    logic [CW-1:0] v;
    wr(1, 2, 32'h02); wr(1, 0, 0);
    pulse(8'h04, 3);
    rd(1, 0, v); check("R3 non-owner select ignored without bit 7", v, 0);
    wr(1, 2, 32'h82);
    pulse(8'h04, 3);
    rd(1, 0, v); check("R3 select taken with bit 7", v, 3);
    wr(4, 2, 32'h183); wr(4, 0, 0);
    pulse(8'h08, 2);
    rd(4, 0, v); check("R3 bit 8 overrides select 3", v, 0);
    pulse(8'h01, 2);
    rd(4, 0, v); check("R3 bit 8 forces source 0", v, 2);
    wr(3, 2, 32'h3FF);
    rd(3, 2, v); check("R4 low channel keeps 8 bits", v, 32'hFF);
    wr(5, 2, 32'h3FF);
    rd(5, 2, v); check("R4 high channel keeps 10 bits", v, 32'h3FF);
    wr(5, 2, 0); wr(3, 2, 0);
  endtask

  task automatic t_shared_oneshot;
    logic [CW-1:0] v;
    irq_en = 8'h04;
    wr(2, 2, 32'h00); wr(2, 1, 4); wr(0, 0, 0);
    pulse(8'h01, 3);
    check("R2 no match before shared counter 0 reaches 4", CW'(sts[2]), 0);
    pulse(8'h01, 1);
    check("R2 channel 2 matches on counter 0", CW'(sts[2]), 1);
    check("R9 irq follows status", CW'(irq), 1);
    clear(8'h04);
    check("R9 clear drops irq", CW'(irq), 0);
    wr(0, 0, 0);
    pulse(8'h01, 4);
    check("R7 one-shot does not match again", CW'(sts[2]), 0);
    irq_en = 0;
  endtask

  task automatic t_periodic;
    logic [CW-1:0] v;
    irq_en = 8'h08;
    wr(3, 2, 32'hC8); wr(3, 1, 3); wr(3, 0, 0);
    pulse(8'h01, 2);
    check("R2 own counter not yet at match", CW'(sts[3]), 0);
    pulse(8'h01, 1);
    check("R2 own counter 3 matches", CW'(sts[3]), 1);
    rd(3, 0, v); check("R6 counter cleared on match", v, 0);
    clear(8'h08);
    pulse(8'h01, 3);
    check("R7 periodic matches again", CW'(sts[3]), 1);
  endtask

  task automatic t_enable;
    irq_en = 8'h08;
    wr(6, 2, 32'h80); wr(6, 1, 2); wr(6, 0, 0);
    pulse(8'h01, 2);
    check("R5 disabled channel leaves status clear", CW'(sts[6]), 0);
    irq_en = 8'h48;
    wr(6, 1, 2); wr(6, 0, 0);
    pulse(8'h01, 2);
    check("R5 enabled channel sets status", CW'(sts[6]), 1);
    clear(8'h08);
    check("R9 irq held by remaining bit", CW'(irq), 1);
    clear(8'h40);
    check("R9 irq falls when all clear", CW'(irq), 0);
    irq_en = 0;
  endtask

  task automatic t_snapshot;
    logic [CW-1:0] v;
    wr(5, 2, 32'h200); wr(4, 0, 37);
    rd(5, 0, v);
    rd(0, 3, v); check("R8 snapshot copies counter 4", v, 37);
    wr(7, 2, 32'h000); wr(6, 0, 9);
    rd(7, 0, v);
    rd(0, 3, v); check("R8 no snapshot without bit 9", v, 37);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_count();
    t_select();
    t_shared_oneshot();
    t_periodic();
    t_enable();
    t_snapshot();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule